// File: doc/BRIEF.md
# Atomic Compare-and-Exchange Execution Unit

This unit carries out one compare-and-exchange operation on an 8-, 16- or 32-bit operand. The destination is either a register, whose value the issuing pipeline supplies with the start pulse, or a memory location reached through a request/response port. The unit compares the low portion of the accumulator with the destination. On a match it writes the source value into the destination. Otherwise it loads the destination value into the accumulator. It also produces arithmetic flags as if the destination had been subtracted from the accumulator, and it reports how many cycles the operation is charged.

A feature-enable input decides whether the operation is supported. When it is low, the unit raises an illegal-opcode fault and returns the start address of the instruction. It touches no memory and updates nothing. The memory port may report an abort on any response. The unit then ends the operation at once, without the write or flag update that would otherwise follow.

Requests leave on a valid/ready handshake. Once the unit raises `mem_req_valid`, it holds the request and its payload unchanged until the cycle in which `mem_req_ready` is high. A request is accepted on the rising edge where both are high. The memory side may stall the unit for any number of cycles by holding ready low. Responses are single-cycle pulses on `mem_rsp_valid` that the unit always accepts, so the response side has no back-pressure. Results appear as one-cycle write strobes together with `done`.

Top module: `cas_exec_unit`

## Requirements
- R1: When `start` is accepted with `feat_en` low, `done` and `fault_ill` are high in the next cycle and `pc_out` equals the `insn_pc` given with the start. No memory request is issued, and `acc_we`, `dst_we` and `flags_we` stay low.
- R2: When the accumulator's low portion equals the destination, the source value is written to the destination and `acc_we` stays low. For a register destination this is `dst_we`, with `dst_wdata` holding the register's upper bits and the source in the low portion. For a memory destination it is one write request with `mem_req_we`=1 and `mem_req_wdata` equal to the source masked to the width.
- R3: When they differ, `acc_we` pulses with `done` and `acc_wdata` holds the accumulator's upper bits with the destination value in the low portion. No destination write and no memory write request occur.
- R4: The flags are those of (accumulator − destination) at the selected width. `flags_out` bit 0 is borrow (CF), bit 1 is even parity of the low result byte (PF), bit 2 is the carry out of bit 3 (AF), bit 3 is a zero result (ZF), bit 4 is the result's top bit (SF) and bit 5 is signed overflow (OF). They are delivered with `flags_we` on completion.
- R5: An abort on the read response ends the operation with `done` and `aborted` high. No write request is issued, `flags_we`, `acc_we` and `dst_we` stay low, and `cycles` is 0.
- R6: An abort on the write-back response ends the operation with `done` and `aborted` high and `flags_we` low.
- R7: On a completed operation, `cycles` is 6 for a register destination and 10 for a memory destination. It is 0 on a fault or abort.
- R8: The width code is 0 for 8 bits, 1 for 16 bits and 2 (or 3) for 32 bits. Accumulator bits above the selected width do not affect the comparison or the flags.
- R9: A memory request keeps `mem_req_valid`, address, write enable and write data stable until accepted. `mem_req_size` carries the width code and `mem_req_addr` the given address.
- R10: With a register destination, `done` is high in the second cycle after the cycle in which `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| feat_en | input | 1 | Operation supported; low raises illegal-opcode fault |
| width | input | 2 | Operand width code |
| dst_is_mem | input | 1 | Destination is in memory |
| insn_pc | input | 32 | Start address of the instruction |
| acc_in | input | 32 | Accumulator value |
| src_in | input | 32 | Source register value |
| dst_reg_in | input | 32 | Destination register value (register case) |
| mem_addr_in | input | 32 | Destination address (memory case) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Request address |
| mem_req_wdata | output | 32 | Write data |
| mem_req_size | output | 2 | Width code of the access |
| mem_rsp_valid | input | 1 | Response pulse |
| mem_rsp_data | input | 32 | Read data |
| mem_rsp_abort | input | 1 | Access aborted |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (one cycle) |
| fault_ill | output | 1 | Illegal-opcode fault, with done |
| pc_out | output | 32 | Restart address, valid with fault_ill |
| aborted | output | 1 | Operation cancelled by memory abort, with done |
| acc_we | output | 1 | Accumulator write strobe |
| acc_wdata | output | 32 | New accumulator value |
| dst_we | output | 1 | Destination register write strobe |
| dst_wdata | output | 32 | New destination register value |
| flags_we | output | 1 | Flag update strobe |
| flags_out | output | 6 | Flag values |
| cycles | output | 4 | Charged latency, with done |

## Verification
Several properties are checked on every cycle by the assertions. They cover stability of a stalled memory request and the fault response with its restart address. They also cover the quiet ending of an aborted operation, the latency value on any flag update, and the agreement between the zero flag and the choice of accumulator load or destination write. The scenarios are needed for everything that depends on data values. That includes the exact merged accumulator and destination words, the flag bits for borrow, overflow and half-carry cases, the masking of upper accumulator bits, the number of read and write requests, and the register-path timing.

// File: rtl/cas_pkg.sv
package cas_pkg;

  typedef enum logic [1:0] {
    CAS_W8  = 2'd0,
    CAS_W16 = 2'd1,
    CAS_W32 = 2'd2
  } cas_width_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_EXEC    = 3'd1,
    ST_RD_REQ  = 3'd2,
    ST_RD_WAIT = 3'd3,
    ST_WR_REQ  = 3'd4,
    ST_WR_WAIT = 3'd5
  } cas_state_e;

  localparam int NUM_FLAGS = 6;
  localparam int FLG_CF = 0;
  localparam int FLG_PF = 1;
  localparam int FLG_AF = 2;
  localparam int FLG_ZF = 3;
  localparam int FLG_SF = 4;
  localparam int FLG_OF = 5;

endpackage

// File: rtl/cas_lane_ops.sv
module cas_lane_ops #(
  parameter int LANE_BASE = 8,
  parameter int NUM_LANES = 3,
  parameter int DATA_W    = LANE_BASE << (NUM_LANES - 1),
  parameter int SEL_W     = $clog2(NUM_LANES)
) (
  input  logic [SEL_W-1:0]  lane_sel,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst_old,
  output logic              equal,
  output logic [DATA_W-1:0] acc_merged,
  output logic [DATA_W-1:0] dst_merged,
  output logic [DATA_W-1:0] src_masked
);

  logic [DATA_W-1:0] lane_mask [NUM_LANES];
  logic [DATA_W-1:0] mask;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_mask
    localparam int LW = LANE_BASE << i;
    assign lane_mask[i] = {DATA_W{1'b1}} >> (DATA_W - LW);
  end

  assign mask       = lane_mask[lane_sel];
  assign equal      = ((acc ^ opnd) & mask) == '0;
  assign acc_merged = (acc & ~mask) | (opnd & mask);
  assign dst_merged = (dst_old & ~mask) | (src & mask);
  assign src_masked = src & mask;

endmodule

// File: rtl/cas_flag_calc.sv
module cas_flag_calc
  import cas_pkg::*;
#(
  parameter int LANE_BASE = 8,
  parameter int NUM_LANES = 3,
  parameter int DATA_W    = LANE_BASE << (NUM_LANES - 1),
  parameter int SEL_W     = $clog2(NUM_LANES)
) (
  input  logic [SEL_W-1:0]     lane_sel,
  input  logic [DATA_W-1:0]    minuend,
  input  logic [DATA_W-1:0]    subtrahend,
  output logic [NUM_FLAGS-1:0] flags
);

  logic [NUM_FLAGS-1:0] lane_flags [NUM_LANES];

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    localparam int LW = LANE_BASE << i;
    logic [LW:0]          diff;
    logic [NUM_FLAGS-1:0] fv;

    assign diff = {1'b0, minuend[LW-1:0]} - {1'b0, subtrahend[LW-1:0]};

    always_comb begin
      fv         = '0;
      fv[FLG_CF] = diff[LW];
      fv[FLG_ZF] = diff[LW-1:0] == '0;
      fv[FLG_SF] = diff[LW-1];
      fv[FLG_OF] = (minuend[LW-1] ^ subtrahend[LW-1]) & (diff[LW-1] ^ minuend[LW-1]);
      fv[FLG_AF] = minuend[4] ^ subtrahend[4] ^ diff[4];
      fv[FLG_PF] = ~^diff[7:0];
    end

    assign lane_flags[i] = fv;
  end

  assign flags = lane_flags[lane_sel];

endmodule

// File: rtl/cas_exec_unit.sv
module cas_exec_unit
  import cas_pkg::*;
#(
  parameter int LANE_BASE  = 8,
  parameter int NUM_LANES  = 3,
  parameter int ADDR_W     = 32,
  parameter int REG_CYCLES = 6,
  parameter int MEM_CYCLES = 10,
  parameter int DATA_W     = LANE_BASE << (NUM_LANES - 1),
  parameter int WCODE_W    = $clog2(NUM_LANES),
  parameter int CYC_W      = $clog2(MEM_CYCLES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 feat_en,
  input  logic [WCODE_W-1:0]   width,
  input  logic                 dst_is_mem,
  input  logic [ADDR_W-1:0]    insn_pc,
  input  logic [DATA_W-1:0]    acc_in,
  input  logic [DATA_W-1:0]    src_in,
  input  logic [DATA_W-1:0]    dst_reg_in,
  input  logic [ADDR_W-1:0]    mem_addr_in,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic                 mem_req_we,
  output logic [ADDR_W-1:0]    mem_req_addr,
  output logic [DATA_W-1:0]    mem_req_wdata,
  output logic [WCODE_W-1:0]   mem_req_size,
  input  logic                 mem_rsp_valid,
  input  logic [DATA_W-1:0]    mem_rsp_data,
  input  logic                 mem_rsp_abort,
  output logic                 busy,
  output logic                 done,
  output logic                 fault_ill,
  output logic [ADDR_W-1:0]    pc_out,
  output logic                 aborted,
  output logic                 acc_we,
  output logic [DATA_W-1:0]    acc_wdata,
  output logic                 dst_we,
  output logic [DATA_W-1:0]    dst_wdata,
  output logic                 flags_we,
  output logic [NUM_FLAGS-1:0] flags_out,
  output logic [CYC_W-1:0]     cycles
);

  localparam logic [WCODE_W-1:0] TOP_LANE = WCODE_W'(NUM_LANES - 1);

  cas_state_e         state;
  logic [WCODE_W-1:0] width_q;
  logic [WCODE_W-1:0] lane_sel;
  logic               is_mem_q;
  logic [DATA_W-1:0]  acc_q, src_q, dst_q, op_q;
  logic [ADDR_W-1:0]  addr_q;

  logic                 cmp_equal;
  logic [DATA_W-1:0]    acc_merged, dst_merged, src_masked;
  logic [NUM_FLAGS-1:0] flags_c;

  // Width codes beyond the widest lane fall back to the widest lane.
  assign lane_sel = (width_q > TOP_LANE) ? TOP_LANE : width_q;

  cas_lane_ops #(
    .LANE_BASE(LANE_BASE), .NUM_LANES(NUM_LANES), .DATA_W(DATA_W), .SEL_W(WCODE_W)
  ) u_lanes (
    .lane_sel  (lane_sel),
    .acc       (acc_q),
    .opnd      (op_q),
    .src       (src_q),
    .dst_old   (dst_q),
    .equal     (cmp_equal),
    .acc_merged(acc_merged),
    .dst_merged(dst_merged),
    .src_masked(src_masked)
  );

  cas_flag_calc #(
    .LANE_BASE(LANE_BASE), .NUM_LANES(NUM_LANES), .DATA_W(DATA_W), .SEL_W(WCODE_W)
  ) u_flags (
    .lane_sel  (lane_sel),
    .minuend   (acc_q),
    .subtrahend(op_q),
    .flags     (flags_c)
  );

  assign busy          = state != ST_IDLE;
  assign mem_req_valid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
  assign mem_req_we    = state == ST_WR_REQ;
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = src_masked;
  assign mem_req_size  = width_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      width_q   <= '0;
      is_mem_q  <= 1'b0;
      acc_q     <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      op_q      <= '0;
      addr_q    <= '0;
      done      <= 1'b0;
      fault_ill <= 1'b0;
      pc_out    <= '0;
      aborted   <= 1'b0;
      acc_we    <= 1'b0;
      acc_wdata <= '0;
      dst_we    <= 1'b0;
      dst_wdata <= '0;
      flags_we  <= 1'b0;
      flags_out <= '0;
      cycles    <= '0;
    end else begin
      done      <= 1'b0;
      fault_ill <= 1'b0;
      aborted   <= 1'b0;
      acc_we    <= 1'b0;
      dst_we    <= 1'b0;
      flags_we  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (!feat_en) begin
              done      <= 1'b1;
              fault_ill <= 1'b1;
              pc_out    <= insn_pc;
              cycles    <= '0;
            end else begin
              width_q  <= width;
              is_mem_q <= dst_is_mem;
              acc_q    <= acc_in;
              src_q    <= src_in;
              dst_q    <= dst_reg_in;
              op_q     <= dst_reg_in;
              addr_q   <= mem_addr_in;
              state    <= dst_is_mem ? ST_RD_REQ : ST_EXEC;
            end
          end
        end
        ST_EXEC: begin
          if (cmp_equal && is_mem_q) begin
            state <= ST_WR_REQ;
          end else begin
            done      <= 1'b1;
            flags_we  <= 1'b1;
            flags_out <= flags_c;
            cycles    <= is_mem_q ? CYC_W'(MEM_CYCLES) : CYC_W'(REG_CYCLES);
            if (cmp_equal) begin
              dst_we    <= 1'b1;
              dst_wdata <= dst_merged;
            end else begin
              acc_we    <= 1'b1;
              acc_wdata <= acc_merged;
            end
            state <= ST_IDLE;
          end
        end
        ST_RD_REQ: begin
          if (mem_req_ready) state <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_abort) begin
              done    <= 1'b1;
              aborted <= 1'b1;
              cycles  <= '0;
              state   <= ST_IDLE;
            end else begin
              op_q  <= mem_rsp_data;
              state <= ST_EXEC;
            end
          end
        end
        ST_WR_REQ: begin
          if (mem_req_ready) state <= ST_WR_WAIT;
        end
        ST_WR_WAIT: begin
          if (mem_rsp_valid) begin
            done  <= 1'b1;
            state <= ST_IDLE;
            if (mem_rsp_abort) begin
              aborted <= 1'b1;
              cycles  <= '0;
            end else begin
              flags_we  <= 1'b1;
              flags_out <= flags_c;
              cycles    <= CYC_W'(MEM_CYCLES);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: disabled feature faults at once with the restart address
  a_r1_fault_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start && !feat_en) |=>
      (done && fault_ill && pc_out == $past(insn_pc) && !flags_we && !acc_we && !dst_we));

  // R9: a stalled request holds its payload
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));

  // R5: an aborted operation leaves no trace
  a_r5_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done && aborted) |-> (!flags_we && !acc_we && !dst_we && cycles == '0));

  // R7: every flag update carries one of the two latencies
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |-> (done && (cycles == CYC_W'(REG_CYCLES) || cycles == CYC_W'(MEM_CYCLES))));

  // R2: a match never reloads the accumulator
  a_r2_match_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_we && flags_out[FLG_ZF]) |-> !acc_we);

  // R3: a mismatch reloads the accumulator and writes no destination
  a_r3_miss_loads_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_we && !flags_out[FLG_ZF]) |-> (acc_we && !dst_we));

endmodule

// File: tb/cas_exec_unit_tb.sv
module cas_exec_unit_tb;

  localparam time CLK_HALF = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        feat_en = 1'b1;
  logic [1:0]  width = '0;
  logic        dst_is_mem = 1'b0;
  logic [31:0] insn_pc = '0, acc_in = '0, src_in = '0, dst_reg_in = '0, mem_addr_in = '0;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [1:0]  mem_req_size;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_rsp_abort = 1'b0;
  logic        busy, done, fault_ill, aborted, acc_we, dst_we, flags_we;
  logic [31:0] pc_out, acc_wdata, dst_wdata;
  logic [5:0]  flags_out;
  logic [3:0]  cycles;

  int n_checks = 0;
  int n_fails  = 0;

  // captured results of one operation
  logic        c_done, c_fault, c_abort, c_acc_we, c_dst_we, c_flags_we, hold_ok;
  logic [31:0] c_pc, c_acc, c_dst, w_addr, w_data;
  logic [5:0]  c_flags;
  logic [3:0]  c_cycles;
  logic [1:0]  w_size;
  int          n_rd, n_wr, edges;

  always #(CLK_HALF) clk = ~clk;

  cas_exec_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .feat_en(feat_en), .width(width),
    .dst_is_mem(dst_is_mem), .insn_pc(insn_pc), .acc_in(acc_in), .src_in(src_in),
    .dst_reg_in(dst_reg_in), .mem_addr_in(mem_addr_in),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata), .mem_req_size(mem_req_size),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_abort(mem_rsp_abort),
    .busy(busy), .done(done), .fault_ill(fault_ill), .pc_out(pc_out), .aborted(aborted),
    .acc_we(acc_we), .acc_wdata(acc_wdata), .dst_we(dst_we), .dst_wdata(dst_wdata),
    .flags_we(flags_we), .flags_out(flags_out), .cycles(cycles)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] gold_flags(input logic [1:0] w, input logic [31:0] a, input logic [31:0] b);
    int n;
    logic [31:0] m, am, bm, r;
    logic [5:0] f;
    n  = (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
    m  = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    am = a & m;
    bm = b & m;
    r  = (am - bm) & m;
    f    = '0;
    f[0] = am < bm;
    f[1] = ~^r[7:0];
    f[2] = a[4] ^ b[4] ^ r[4];
    f[3] = r == 32'd0;
    f[4] = r[n-1];
    f[5] = (am[n-1] != bm[n-1]) && (r[n-1] != am[n-1]);
    return f;
  endfunction

  task automatic run_op(input logic en, input logic [1:0] w, input logic mem,
                        input logic [31:0] acc, input logic [31:0] src, input logic [31:0] dreg,
                        input logic [31:0] addr, input logic [31:0] pc, input logic [31:0] rd_data,
                        input logic rd_ab, input logic wr_ab, input int rdy_dly);
    int guard;
    logic [31:0] a0, d0;
    logic we0;
    c_done = 0; n_rd = 0; n_wr = 0; hold_ok = 1; edges = 0; guard = 0;
    w_addr = '0; w_data = '0; w_size = '0;
    @(negedge clk);
    feat_en = en; width = w; dst_is_mem = mem; acc_in = acc; src_in = src;
    dst_reg_in = dreg; mem_addr_in = addr; insn_pc = pc; start = 1'b1;
    @(negedge clk); edges++;
    start = 1'b0;
    while (!c_done && guard < 200) begin
      guard++;
      if (done) begin
        c_done = 1; c_fault = fault_ill; c_abort = aborted; c_pc = pc_out;
        c_acc_we = acc_we; c_acc = acc_wdata; c_dst_we = dst_we; c_dst = dst_wdata;
        c_flags_we = flags_we; c_flags = flags_out; c_cycles = cycles;
      end else if (mem_req_valid) begin
        a0 = mem_req_addr; d0 = mem_req_wdata; we0 = mem_req_we;
        for (int k = 0; k < rdy_dly; k++) begin
          @(negedge clk); edges++;
          if (!mem_req_valid || mem_req_addr !== a0 || mem_req_wdata !== d0 || mem_req_we !== we0)
            hold_ok = 0;
        end
        if (we0) begin
          n_wr++; w_addr = a0; w_data = d0; w_size = mem_req_size;
        end else begin
          n_rd++; w_addr = a0; w_size = mem_req_size;
        end
        mem_req_ready = 1'b1;
        @(negedge clk); edges++;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = we0 ? 32'h0 : rd_data;
        mem_rsp_abort = we0 ? wr_ab : rd_ab;
        @(negedge clk); edges++;
        mem_rsp_valid = 1'b0;
        mem_rsp_abort = 1'b0;
      end else begin
        @(negedge clk); edges++;
      end
    end
    chk("R1", "operation completes", 32'(c_done), 32'd1);
  endtask

  task automatic t_reset;
    chk("R1", "reset done", 32'(done), 0);
    chk("R9", "reset req valid", 32'(mem_req_valid), 0);
    chk("R1", "reset busy", 32'(busy), 0);
    chk("R4", "reset flags_we", 32'(flags_we), 0);
  endtask

  task automatic t_fault;
    run_op(1'b0, 2'd2, 1'b1, 32'h5, 32'h6, 32'h7, 32'h200, 32'h1234_5678, 32'h5, 1'b0, 1'b0, 0);
    chk("R1", "fault flag", 32'(c_fault), 1);
    chk("R1", "restart pc", c_pc, 32'h1234_5678);
    chk("R1", "fault latency edges", 32'(edges), 1);
    chk("R1", "no memory access", 32'(n_rd + n_wr), 0);
    chk("R1", "no flag update", 32'(c_flags_we), 0);
    chk("R1", "no acc write", 32'(c_acc_we), 0);
    chk("R1", "no dst write", 32'(c_dst_we), 0);
    chk("R7", "fault cycles", 32'(c_cycles), 0);
  endtask

  task automatic t_reg_equal;
    run_op(1'b1, 2'd2, 1'b0, 32'hDEAD_BEEF, 32'h1111_2222, 32'hDEAD_BEEF, 0, 0, 0, 1'b0, 1'b0, 0);
    chk("R2", "dst_we", 32'(c_dst_we), 1);
    chk("R2", "dst_wdata", c_dst, 32'h1111_2222);
    chk("R2", "acc untouched", 32'(c_acc_we), 0);
    chk("R4", "flags", 32'(c_flags), 32'(gold_flags(2'd2, 32'hDEAD_BEEF, 32'hDEAD_BEEF)));
    chk("R7", "register cycles", 32'(c_cycles), 6);
    chk("R10", "register done timing", 32'(edges), 2);
    chk("R2", "no memory access", 32'(n_rd + n_wr), 0);
  endtask

  task automatic t_reg_miss8;
    run_op(1'b1, 2'd0, 1'b0, 32'hAABB_CC10, 32'h55, 32'h1234_5620, 0, 0, 0, 1'b0, 1'b0, 0);
    chk("R3", "acc_we", 32'(c_acc_we), 1);
    chk("R3", "acc merged", c_acc, 32'hAABB_CC20);
    chk("R3", "no dst write", 32'(c_dst_we), 0);
    chk("R4", "flags 0x10-0x20", 32'(c_flags), 32'(gold_flags(2'd0, 32'h10, 32'h20)));
    chk("R4", "flags literal", 32'(c_flags), 32'h13);
  endtask

  task automatic t_reg_merge16;
    run_op(1'b1, 2'd1, 1'b0, 32'h0000_00AA, 32'hFFFF_BEEF, 32'h7777_00AA, 0, 0, 0, 1'b0, 1'b0, 0);
    chk("R2", "16-bit dst merge", c_dst, 32'h7777_BEEF);
    chk("R8", "16-bit match", 32'(c_dst_we), 1);
  endtask

  task automatic t_mem_equal16;
    run_op(1'b1, 2'd1, 1'b1, 32'h9999_4321, 32'hABCD_8765, 32'h0, 32'h0000_0100, 0,
           32'hFFFF_4321, 1'b0, 1'b0, 3);
    chk("R9", "one read", 32'(n_rd), 1);
    chk("R2", "one write", 32'(n_wr), 1);
    chk("R2", "write data masked", w_data, 32'h0000_8765);
    chk("R9", "write address", w_addr, 32'h100);
    chk("R9", "access size", 32'(w_size), 1);
    chk("R9", "stalled request stable", 32'(hold_ok), 1);
    chk("R2", "acc untouched", 32'(c_acc_we), 0);
    chk("R8", "upper acc bits ignored, ZF", 32'(c_flags[3]), 1);
    chk("R7", "memory cycles", 32'(c_cycles), 10);
  endtask

  task automatic t_mem_miss32;
    run_op(1'b1, 2'd2, 1'b1, 32'd5, 32'h1, 32'h0, 32'h40, 0, 32'd7, 1'b0, 1'b0, 1);
    chk("R3", "no write", 32'(n_wr), 0);
    chk("R3", "acc loaded", c_acc, 32'd7);
    chk("R3", "acc_we", 32'(c_acc_we), 1);
    chk("R4", "flags 5-7", 32'(c_flags), 32'(gold_flags(2'd2, 32'd5, 32'd7)));
    chk("R7", "memory cycles", 32'(c_cycles), 10);
  endtask

  task automatic t_rd_abort;
    run_op(1'b1, 2'd2, 1'b1, 32'd1, 32'h9, 32'h0, 32'h80, 0, 32'd1, 1'b1, 1'b0, 0);
    chk("R5", "aborted", 32'(c_abort), 1);
    chk("R5", "no write", 32'(n_wr), 0);
    chk("R5", "no flags", 32'(c_flags_we), 0);
    chk("R5", "no acc write", 32'(c_acc_we), 0);
    chk("R5", "cycles zero", 32'(c_cycles), 0);
  endtask

  task automatic t_wr_abort;
    run_op(1'b1, 2'd0, 1'b1, 32'h33, 32'h44, 32'h0, 32'h90, 0, 32'h33, 1'b0, 1'b1, 2);
    chk("R6", "aborted", 32'(c_abort), 1);
    chk("R6", "write attempted", 32'(n_wr), 1);
    chk("R6", "no flags", 32'(c_flags_we), 0);
    chk("R6", "no acc write", 32'(c_acc_we), 0);
  endtask

  task automatic t_flag_corners;
    run_op(1'b1, 2'd0, 1'b0, 32'h80, 32'h0, 32'h01, 0, 0, 0, 1'b0, 1'b0, 0);
    chk("R4", "8-bit overflow flags", 32'(c_flags), 32'(gold_flags(2'd0, 32'h80, 32'h01)));
    chk("R4", "8-bit overflow literal", 32'(c_flags), 32'h24);
    run_op(1'b1, 2'd1, 1'b0, 32'hFFFF_0000, 32'h0, 32'h0000_0001, 0, 0, 0, 1'b0, 1'b0, 0);
    chk("R4", "16-bit borrow flags", 32'(c_flags), 32'(gold_flags(2'd1, 32'h0, 32'h1)));
    chk("R8", "16-bit acc merge", c_acc, 32'hFFFF_0001);
    run_op(1'b1, 2'd3, 1'b0, 32'h8000_0000, 32'h0, 32'h0000_0001, 0, 0, 0, 1'b0, 1'b0, 0);
    chk("R8", "width code 3 as 32-bit", 32'(c_flags), 32'(gold_flags(2'd2, 32'h8000_0000, 32'h1)));
  endtask

  initial begin
    #(CLK_HALF * 2 * 100000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fault();
    t_reg_equal();
    t_reg_miss8();
    t_reg_merge16();
    t_mem_equal16();
    t_mem_miss32();
    t_rd_abort();
    t_wr_abort();
    t_flag_corners();
    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule